// File: doc/BRIEF.md
# SPI Master Word Shifter

This block is the shift engine of an SPI master with a small word-wide register port. Software configures the serial format, picks a slave through an active-low select register, and writes characters into a transmit FIFO. While the core is enabled and in master mode, the engine pops one character at a time, drives it out on the data-out line and samples the data-in line into a receive word. That word is pushed into a receive FIFO, and software reads it back through the receive register. The serial clock timing comes from an external tick input. Each tick is one serial clock edge, so a character of n bits lasts 2n ticks.

Clock polarity, clock phase, bit order and character length sit in the mode register. Those fields are frozen while the enable bit is set, and only the enable bit itself can be written then. A character is 4 to 16 bits long, or a full 32 bits. Its alignment inside the 32-bit transmit and receive words depends on the bit order. The event register shows the two FIFO levels and two sticky error flags; writing 1 to a sticky flag clears it.

Internally the transmit FIFO, the shifter and the receive FIFO are joined by valid/ready streams. A register write to a full transmit FIFO is dropped. The shifter takes a character only when it is idle, the core is enabled and in master mode, and the transmit stream is valid. The receive stream has no back-pressure on the shifter: a character completed while the receive FIFO is full is discarded and the overrun flag is set.

Top module: `spi_word_master`

## Requirements
- R1: After reset, the register reads are as follows. Address 0 (capability) reads the FIFO depth in bits 15:8 and zero elsewhere. Address 1 (mode) reads 0. Address 2 (events) reads 0x1, which is not-full set and everything else clear. Address 5 (slave select) reads all ones, as do the select pins. The serial clock and data-out pins are both 0.
- R2: The mode register (address 1) has this layout: bit 0 enable, bit 1 master, bit 4 clock polarity, bit 5 clock phase, bit 6 MSB-first, bits 11:8 length code. While enable reads 1, a write changes only the enable bit and leaves every other field unchanged.
- R3: A write to the transmit register (address 3) is discarded while enable is 0. A transfer starts only when enable and master are both 1 and the transmit FIFO holds a character.
- R4: The serial clock rests at the polarity bit. It toggles once per tick during a character, 2n times for an n-bit character, and ends at the rest level. With phase 0, data is sampled on the first edge of each bit; with phase 1, on the second.
- R5: With MSB-first set and n below 32, transmit bit 31 goes out first, followed by bits 30, 29 and so on. The received character is returned with its LSB at bit 16 and its first-received bit as its MSB.
- R6: With MSB-first clear and n below 32, transmit bit 0 goes out first, followed by bits 1, 2 and so on. The received character is returned occupying bits 15 down to 16-n, with its first-received bit as its LSB.
- R7: Length code 0 selects a 32-bit character. Transmit and receive then use the whole word unshifted: bit 31 travels first when MSB-first is set and bit 0 travels first when it is clear.
- R8: Length codes 3 to 15 give n = code + 1 bits. Codes 1 and 2 are treated as 4 bits.
- R9: Event bit 0 reads 1 while the transmit FIFO is not full. Event bit 1 reads 1 while the receive FIFO is not empty.
- R10: A character completed while the receive FIFO is full is dropped and sets event bit 2 (overrun). The characters already held are read back unchanged and in order.
- R11: A read of the receive register (address 4) while the receive FIFO is empty returns 0 and sets event bit 3 (underrun).
- R12: Writing 1 to event bit 2 or bit 3 clears that flag, and writing 0 leaves it unchanged. If an overrun occurs in the same cycle as a write that clears it, the flag ends up set.
- R13: The slave-select register (address 5) drives the active-low select pins directly. Writing the inverse of one-hot bit k-1 selects slave k alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected address, valid in the cycle of the strobe |
| sck_tick | input | 1 | Serial clock edge request from the external rate generator |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NSS | Active-low slave selects |

## Verification
A completing character can raise the overrun flag in exactly the cycle that software writes 1 to clear it. The bench first fills the receive FIFO, then starts one more character and counts serial clock toggles itself. Right after the final toggle it places the clearing write so that it lands on the same clock edge as the failed receive push. It then expects the overrun flag to read back set, and it checks separately that a plain clearing write does clear it.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  localparam logic [2:0] A_CAPS  = 3'd0;
  localparam logic [2:0] A_MODE  = 3'd1;
  localparam logic [2:0] A_EVENT = 3'd2;
  localparam logic [2:0] A_TXD   = 3'd3;
  localparam logic [2:0] A_RXD   = 3'd4;
  localparam logic [2:0] A_SSEL  = 3'd5;

  localparam int M_EN     = 0;
  localparam int M_MASTER = 1;
  localparam int M_CPOL   = 4;
  localparam int M_CPHA   = 5;
  localparam int M_MSB    = 6;
  localparam int M_LEN    = 8;

  localparam int E_NF = 0;
  localparam int E_NE = 1;
  localparam int E_OV = 2;
  localparam int E_UN = 3;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       msb_first;
    logic [3:0] len;
  } spi_fmt_t;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_DONE} sh_state_e;

  // Character length in bits from the length code
  function automatic logic [5:0] char_bits(input logic [3:0] code);
    case (code)
      4'd0:       return 6'd32;
      4'd1, 4'd2: return 6'd4;
      default:    return {2'b00, code} + 6'd1;
    endcase
  endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [WIDTH-1:0] pop_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             push_fire, pop_fire;

  assign push_ready = (cnt_q != FULL_CNT);
  assign pop_valid  = (cnt_q != '0);
  assign pop_data   = mem_q[rd_q];
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_fire) mem_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_fire) wr_q <= bump(wr_q);
      if (pop_fire)  rd_q <= bump(rd_q);
      case ({push_fire, pop_fire})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R9
  fifo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1)) ||
    (cnt_q + CW'(1) == $past(cnt_q)));

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_word_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  spi_fmt_t          fmt,
  input  logic              tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  sh_state_e         state_q;
  logic [WORD_W-1:0] txsr_q, rxsr_q;
  logic [6:0]        edge_q;
  logic [5:0]        nbits_q;
  logic              cpol_q, cpha_q, msb_q;
  logic              sck_q, mosi_q;
  logic              even_edge, last_edge, drive_now, sample_now;

  function automatic logic head_bit(input logic [WORD_W-1:0] sr, input logic msb);
    return msb ? sr[WORD_W-1] : sr[0];
  endfunction

  function automatic logic [WORD_W-1:0] advance(input logic [WORD_W-1:0] sr, input logic msb);
    return msb ? {sr[WORD_W-2:0], 1'b0} : {1'b0, sr[WORD_W-1:1]};
  endfunction

  assign tx_ready   = (state_q == SH_IDLE) && run;
  assign even_edge  = !edge_q[0];
  assign last_edge  = (edge_q == ({nbits_q, 1'b0} - 7'd1));
  assign drive_now  = cpha_q ? even_edge : (!even_edge && !last_edge);
  assign sample_now = cpha_q ? !even_edge : even_edge;

  assign rx_valid = (state_q == SH_DONE);
  always_comb begin
    if (nbits_q == 6'd32)  rx_data = rxsr_q;
    else if (msb_q)        rx_data = rxsr_q << HALF_W;
    else                   rx_data = rxsr_q >> HALF_W;
  end

  assign sck  = sck_q;
  assign mosi = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      txsr_q  <= '0;
      rxsr_q  <= '0;
      edge_q  <= '0;
      nbits_q <= 6'd8;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      msb_q   <= 1'b0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
    end else begin
      case (state_q)
        SH_IDLE: begin
          sck_q <= fmt.cpol;
          if (tx_valid && tx_ready) begin
            nbits_q <= char_bits(fmt.len);
            cpol_q  <= fmt.cpol;
            cpha_q  <= fmt.cpha;
            msb_q   <= fmt.msb_first;
            edge_q  <= '0;
            rxsr_q  <= '0;
            if (fmt.cpha) begin
              txsr_q <= tx_data;
            end else begin
              mosi_q <= head_bit(tx_data, fmt.msb_first);
              txsr_q <= advance(tx_data, fmt.msb_first);
            end
            state_q <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 7'd1;
            if (drive_now) begin
              mosi_q <= head_bit(txsr_q, msb_q);
              txsr_q <= advance(txsr_q, msb_q);
            end
            if (sample_now) begin
              rxsr_q <= msb_q ? {rxsr_q[WORD_W-2:0], miso} : {miso, rxsr_q[WORD_W-1:1]};
            end
            if (last_edge) state_q <= SH_DONE;
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  // R4
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_DONE) |-> (sck_q == cpol_q));

  // R4
  sck_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_SHIFT && !tick) |=> $stable(sck_q));

endmodule

// File: rtl/spi_word_regs.sv
module spi_word_regs
  import spi_word_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int NSS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              run,
  output spi_fmt_t          fmt,
  output logic              tx_push_valid,
  input  logic              tx_push_ready,
  output logic [WORD_W-1:0] tx_push_data,
  input  logic              rx_pop_valid,
  output logic              rx_pop_ready,
  input  logic [WORD_W-1:0] rx_pop_data,
  input  logic              rx_drop,
  output logic [NSS-1:0]    ss_n
);

  localparam logic [7:0] DEPTH_CODE = 8'(DEPTH);

  logic           en_q, master_q, ov_q, un_q;
  spi_fmt_t       fmt_q;
  logic [NSS-1:0] ss_q;
  logic           wr_mode, wr_ev, wr_ss, wr_tx, rd_rx, un_evt;

  assign wr_mode = bus_sel && bus_we && (bus_addr == A_MODE);
  assign wr_ev   = bus_sel && bus_we && (bus_addr == A_EVENT);
  assign wr_ss   = bus_sel && bus_we && (bus_addr == A_SSEL);
  assign wr_tx   = bus_sel && bus_we && (bus_addr == A_TXD);
  assign rd_rx   = bus_sel && !bus_we && (bus_addr == A_RXD);
  assign un_evt  = rd_rx && !rx_pop_valid;

  assign run           = en_q && master_q;
  assign fmt           = fmt_q;
  assign tx_push_valid = wr_tx && en_q;
  assign tx_push_data  = bus_wdata;
  assign rx_pop_ready  = rd_rx;
  assign ss_n          = ss_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CAPS:  bus_rdata[15:8] = DEPTH_CODE;
      A_MODE: begin
        bus_rdata[M_EN]          = en_q;
        bus_rdata[M_MASTER]      = master_q;
        bus_rdata[M_CPOL]        = fmt_q.cpol;
        bus_rdata[M_CPHA]        = fmt_q.cpha;
        bus_rdata[M_MSB]         = fmt_q.msb_first;
        bus_rdata[M_LEN+3:M_LEN] = fmt_q.len;
      end
      A_EVENT: begin
        bus_rdata[E_NF] = tx_push_ready;
        bus_rdata[E_NE] = rx_pop_valid;
        bus_rdata[E_OV] = ov_q;
        bus_rdata[E_UN] = un_q;
      end
      A_RXD:   bus_rdata = rx_pop_valid ? rx_pop_data : '0;
      A_SSEL:  bus_rdata = WORD_W'(ss_q);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      master_q <= 1'b0;
      fmt_q    <= '0;
      ss_q     <= '1;
      ov_q     <= 1'b0;
      un_q     <= 1'b0;
    end else begin
      if (wr_mode) begin
        en_q <= bus_wdata[M_EN];
        if (!en_q) begin
          master_q        <= bus_wdata[M_MASTER];
          fmt_q.cpol      <= bus_wdata[M_CPOL];
          fmt_q.cpha      <= bus_wdata[M_CPHA];
          fmt_q.msb_first <= bus_wdata[M_MSB];
          fmt_q.len       <= bus_wdata[M_LEN+3:M_LEN];
        end
      end
      if (wr_ss) ss_q <= bus_wdata[NSS-1:0];
      ov_q <= rx_drop || (ov_q && !(wr_ev && bus_wdata[E_OV]));
      un_q <= un_evt  || (un_q && !(wr_ev && bus_wdata[E_UN]));
    end
  end

  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> ($stable(fmt_q) && $stable(master_q)));

  // R12
  ov_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ov_q);

  // R11
  un_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_pop_valid) |=> un_q);

  // R13
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ss |=> $stable(ss_q));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int NSS        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              sck_tick,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NSS-1:0]    spi_ss_n
);

  logic              run;
  spi_fmt_t          fmt;
  logic              txf_push_valid, txf_push_ready;
  logic [WORD_W-1:0] txf_push_data;
  logic              txf_pop_valid, txf_pop_ready;
  logic [WORD_W-1:0] txf_pop_data;
  logic              rxf_push_valid, rxf_push_ready;
  logic [WORD_W-1:0] rxf_push_data;
  logic              rxf_pop_valid, rxf_pop_ready;
  logic [WORD_W-1:0] rxf_pop_data;
  logic              rx_drop;

  assign rx_drop = rxf_push_valid && !rxf_push_ready;

  spi_word_regs #(.DEPTH(FIFO_DEPTH), .NSS(NSS)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .run           (run),
    .fmt           (fmt),
    .tx_push_valid (txf_push_valid),
    .tx_push_ready (txf_push_ready),
    .tx_push_data  (txf_push_data),
    .rx_pop_valid  (rxf_pop_valid),
    .rx_pop_ready  (rxf_pop_ready),
    .rx_pop_data   (rxf_pop_data),
    .rx_drop       (rx_drop),
    .ss_n          (spi_ss_n)
  );

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (txf_push_valid),
    .push_ready (txf_push_ready),
    .push_data  (txf_push_data),
    .pop_valid  (txf_pop_valid),
    .pop_ready  (txf_pop_ready),
    .pop_data   (txf_pop_data)
  );

  spi_word_shifter u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .fmt      (fmt),
    .tick     (sck_tick),
    .tx_valid (txf_pop_valid),
    .tx_ready (txf_pop_ready),
    .tx_data  (txf_pop_data),
    .rx_valid (rxf_push_valid),
    .rx_data  (rxf_push_data),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .miso     (spi_miso)
  );

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (rxf_push_valid),
    .push_ready (rxf_push_ready),
    .push_data  (rxf_push_data),
    .pop_valid  (rxf_pop_valid),
    .pop_ready  (rxf_pop_ready),
    .pop_data   (rxf_pop_data)
  );

endmodule

// File: tb/spi_word_master_bench.sv
module spi_word_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        sck_tick = 1'b0;
  logic        spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_ss_n;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  // slave model state
  logic        mon_cpol = 1'b0;
  logic        mon_cpha = 1'b0;
  logic [31:0] sbits = 32'd0;
  logic        cap [0:63];
  int          cap_n = 0;
  logic        sck_prev = 1'b0;

  spi_word_master u_spi_word_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_tick(sck_tick), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) sck_tick <= 1'b0;
    else        sck_tick <= ~sck_tick;
  end

  // Slave: records data-out on each sampling edge and presents the next data-in bit
  always @(negedge clk) begin
    if (rst_n && (spi_sck != sck_prev)) begin
      if (mon_cpha ? (spi_sck == mon_cpol) : (spi_sck != mon_cpol)) begin
        if (cap_n < 64) cap[cap_n] = spi_mosi;
        cap_n = cap_n + 1;
        spi_miso = sbits[cap_n % 32];
      end
    end
    sck_prev = spi_sck;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic int bits_of(input int code);
    if (code == 0) return 32;
    if (code < 3) return 4;
    return code + 1;
  endfunction

  function automatic logic [31:0] mode_word(input bit cpol, input bit cpha, input bit msb,
                                            input int code, input bit master);
    return (32'(code) << 8) | (32'(msb) << 6) | (32'(cpha) << 5) | (32'(cpol) << 4) |
           (32'(master) << 1);
  endfunction

  task automatic configure(input bit cpol, input bit cpha, input bit msb, input int code);
    logic [31:0] m;
    m = mode_word(cpol, cpha, msb, code, 1'b1);
    bus_write(3'd1, m);
    bus_write(3'd1, m);
    bus_write(3'd1, m | 32'd1);
    mon_cpol = cpol; mon_cpha = cpha;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] txw, input logic [31:0] schar, input int n,
                      input bit msb, input bit wait_done);
    for (int k = 0; k < 32; k++)
      sbits[k] = (k < n) ? (msb ? schar[n-1-k] : schar[k]) : 1'b0;
    cap_n = 0;
    spi_miso = sbits[0];
    bus_write(3'd3, txw);
    if (wait_done) repeat (4 * n + 12) @(negedge clk);
  endtask

  function automatic logic [31:0] rx_expect(input logic [31:0] schar, input int n, input bit msb);
    logic [31:0] c;
    if (n == 32) return schar;
    c = schar & ((32'd1 << n) - 32'd1);
    return msb ? (c << 16) : (c << (16 - n));
  endfunction

  task automatic run_char(input string req, input bit cpol, input bit cpha, input bit msb,
                          input int code, input logic [31:0] txw, input logic [31:0] schar);
    int n;
    logic [31:0] seq, exp_seq, rd;
    n = bits_of(code);
    configure(cpol, cpha, msb, code);
    send(txw, schar, n, msb, 1'b1);
    // R4: clock back at rest, one sample per bit
    chk({req, " R4 sck rest"}, 32'(spi_sck), 32'(cpol));
    chk({req, " R4 sample count"}, 32'(cap_n), 32'(n));
    seq = '0; exp_seq = '0;
    for (int k = 0; k < n; k++) begin
      seq[k] = cap[k];
      exp_seq[k] = msb ? txw[31-k] : txw[k];
    end
    chk({req, " mosi order"}, seq, exp_seq);
    bus_read(3'd2, rd);
    chk({req, " R9 ne set"}, rd & 32'h3, 32'h3);
    bus_read(3'd4, rd);
    chk({req, " rx placement"}, rd, rx_expect(schar, n, msb));
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    bus_read(3'd0, rd); chk("R1 caps", rd, 32'h0000_0400);
    bus_read(3'd1, rd); chk("R1 mode", rd, 32'h0);
    bus_read(3'd2, rd); chk("R1 events", rd, 32'h1);
    bus_read(3'd5, rd); chk("R1 ssel reg", rd, 32'hF);
    chk("R1 pins", {29'd0, spi_sck, spi_mosi, 1'b0} | 32'(spi_ss_n) << 4, 32'hF0);
  endtask

  task automatic t_ssel;
    logic [31:0] rd;
    bus_write(3'd5, ~(32'd1 << 1));
    bus_read(3'd5, rd); chk("R13 ssel read slave 2", rd, 32'hD);
    chk("R13 ssel pins slave 2", 32'(spi_ss_n), 32'hD);
    bus_write(3'd5, 32'hFFFF_FFFF);
    chk("R13 ssel pins none", 32'(spi_ss_n), 32'hF);
  endtask

  task automatic t_formats;
    run_char("R5 msb 8b mode0", 1'b0, 1'b0, 1'b1, 7,  32'hA500_0000, 32'h0000_00C3);
    run_char("R6 lsb 8b mode3", 1'b1, 1'b1, 1'b0, 7,  32'h0000_0036, 32'h0000_009A);
    run_char("R5 msb 12b mode1", 1'b0, 1'b1, 1'b1, 11, 32'hBCD0_0000, 32'h0000_0E71);
    run_char("R6 lsb 16b mode2", 1'b1, 1'b0, 1'b0, 15, 32'h0000_8421, 32'h0000_F00D);
    run_char("R7 32b lsb mode2", 1'b1, 1'b0, 1'b0, 0,  32'h1234_5678, 32'hCAFE_F00D);
    run_char("R7 32b msb mode0", 1'b0, 1'b0, 1'b1, 0,  32'h8765_4321, 32'h0BAD_BEEF);
    run_char("R8 code1 as 4b msb", 1'b0, 1'b0, 1'b1, 1, 32'h9000_0000, 32'h0000_0006);
    run_char("R8 code3 4b lsb", 1'b0, 1'b1, 1'b0, 3, 32'h0000_000B, 32'h0000_0005);
  endtask

  task automatic t_lock;
    logic [31:0] rd, m;
    configure(1'b0, 1'b0, 1'b1, 7);
    m = mode_word(1'b0, 1'b0, 1'b1, 7, 1'b1) | 32'd1;
    bus_write(3'd1, mode_word(1'b1, 1'b1, 1'b0, 15, 1'b0) | 32'd1);
    bus_read(3'd1, rd); chk("R2 locked fields", rd, m);
    repeat (3) @(negedge clk);
    chk("R2 sck polarity held", 32'(spi_sck), 32'd0);
    bus_write(3'd1, mode_word(1'b1, 1'b1, 1'b0, 15, 1'b0));
    bus_read(3'd1, rd); chk("R2 enable alone cleared", rd, m & ~32'd1);
  endtask

  task automatic t_gate;
    logic [31:0] rd, m;
    m = mode_word(1'b0, 1'b0, 1'b1, 7, 1'b1);
    bus_write(3'd1, 32'd0);
    bus_write(3'd1, m);
    cap_n = 0;
    bus_write(3'd3, 32'hFF00_0000);
    bus_write(3'd1, m | 32'd1);
    repeat (60) @(negedge clk);
    chk("R3 disabled write dropped edges", 32'(cap_n), 32'd0);
    bus_read(3'd2, rd); chk("R3 disabled write no rx", rd, 32'h1);
    // enabled but not master: FIFO fills, nothing shifts
    bus_write(3'd1, 32'd0);
    bus_write(3'd1, m & ~32'd2);
    bus_write(3'd1, (m & ~32'd2) | 32'd1);
    for (int i = 0; i < 4; i++) bus_write(3'd3, 32'h0100_0000 * (i + 1));
    bus_read(3'd2, rd); chk("R9 tx full clears nf", rd, 32'h0);
    repeat (60) @(negedge clk);
    chk("R3 no master no edges", 32'(cap_n), 32'd0);
    bus_write(3'd1, m & ~32'd2);
    bus_write(3'd1, m);
    bus_write(3'd1, m | 32'd1);
    repeat (4 * (4 * 8 + 12)) @(negedge clk);
    chk("R3 master drains fifo", 32'(cap_n), 32'd32);
    bus_read(3'd2, rd); chk("R9 nf and ne after drain", rd, 32'h3);
    for (int i = 0; i < 4; i++) bus_read(3'd4, rd);
    bus_read(3'd2, rd); chk("R9 ne clear after reads", rd, 32'h1);
  endtask

  task automatic t_overrun;
    logic [31:0] rd;
    configure(1'b0, 1'b0, 1'b1, 7);
    for (int i = 1; i <= 4; i++) send(32'h0, 32'h11 * i, 8, 1'b1, 1'b1);
    bus_read(3'd2, rd); chk("R10 full no overrun yet", rd, 32'h3);
    send(32'h0, 32'h55, 8, 1'b1, 1'b1);
    bus_read(3'd2, rd); chk("R10 overrun flag", rd, 32'h7);
    for (int i = 1; i <= 4; i++) begin
      bus_read(3'd4, rd); chk("R10 kept data in order", rd, (32'h11 * i) << 16);
    end
    bus_read(3'd4, rd); chk("R11 empty read zero", rd, 32'h0);
    bus_read(3'd2, rd); chk("R11 underrun flag", rd, 32'hD);
    bus_write(3'd2, 32'h0);
    bus_read(3'd2, rd); chk("R12 write zero keeps", rd, 32'hD);
    bus_write(3'd2, 32'h4);
    bus_read(3'd2, rd); chk("R12 clear overrun only", rd, 32'h9);
    bus_write(3'd2, 32'h8);
    bus_read(3'd2, rd); chk("R12 clear underrun", rd, 32'h1);
  endtask

  task automatic t_collide;
    logic [31:0] rd;
    logic prev;
    int cnt;
    configure(1'b1, 1'b1, 1'b1, 7);
    for (int i = 1; i <= 4; i++) send(32'h0, 32'h20 + i, 8, 1'b1, 1'b1);
    send(32'h0, 32'h77, 8, 1'b1, 1'b0);
    prev = spi_sck; cnt = 0;
    while (cnt < 16) begin
      @(negedge clk);
      if (spi_sck != prev) begin cnt++; prev = spi_sck; end
    end
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h4;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    bus_read(3'd2, rd); chk("R12 set wins over clear", rd & 32'h4, 32'h4);
    bus_write(3'd2, 32'h4);
    bus_read(3'd2, rd); chk("R12 later clear works", rd, 32'h3);
    for (int i = 1; i <= 4; i++) begin
      bus_read(3'd4, rd); chk("R10 held after collision", rd, (32'h20 + i) << 16);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_ssel;
    t_formats;
    t_lock;
    t_gate;
    t_overrun;
    t_collide;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      finished = 1;
      n_vec++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule